// File: doc/BRIEF.md
# Shared Interrupt Prioritizer and Router

The block holds the state of a bank of shared interrupt lines: pending, enabled, active, a one-bit group, an 8-bit priority and a routing word. It finds, for each of several cores, the best eligible interrupt routed to that core. Each interrupt is routed in one of two ways. A direct route sends it to the core whose affinity matches. A one-of-N route sends it to the lowest-numbered core that currently accepts such interrupts for its group. Every core sees a candidate made of an ID, a priority and a group. A priority of 0xFF means the core has no candidate.

All state changes arrive through one command port, and the same pending set and clear commands serve for line assertion and deassertion. Any accepted command, and any change on the participation flags, group enables or core affinities, starts a sequential scan. The scan visits one shared ID per clock from the lowest ID upward. When the last ID has been visited, all candidates are published together and a one-cycle done pulse is raised.

The controller has three states. ST_IDLE goes to ST_SCAN on a change. ST_SCAN advances one ID per cycle. It restarts at the first ID on a change, and goes to ST_DONE after the last ID. ST_DONE returns to ST_IDLE, or goes to ST_SCAN if a change arrives in that cycle.

Top module: `shared_irq_arbiter`

## Requirements
- R1: After reset, every core's candidate priority reads 0xFF and done_o is low.
- R2: An interrupt becomes a candidate only if it is pending, enabled, not active, and grp_en has the bit for its group set. The cmd_op encodings are: 0 set pending, 1 clear pending, 2 set enable, 3 clear enable, 4 set active, 5 clear active, and 6 configure. Configure loads cmd_prio, cmd_grp, cmd_irm and cmd_aff into the interrupt's state.
- R3: Among the eligible interrupts routed to one core, the numerically lowest priority wins. On equal priority, the lowest ID wins. cand_grp reports the winner's group.
- R4: When the mode bit (cmd_irm) is 0, the interrupt goes to a core only if affinity bits 31:8 are zero and bits 7:0 equal that core's byte core_aff[8c+7:8c]. If several cores match, the lowest-numbered one is chosen.
- R5: When the mode bit is 1, the interrupt goes to the lowest-numbered core c whose flag core_part[2c+g] is set, where g is the interrupt's group.
- R6: An interrupt with no matching core is delivered nowhere. It does not stop the other IDs from being considered, and it stays pending, so it appears as soon as a later change gives it a route.
- R7: A clear-pending command forces the priority of the core its interrupt routes to to 0xFF in the cycle right after the command. This happens before the new scan completes, and other cores keep their candidates.
- R8: After a change, done_o pulses for exactly one cycle, NUM_SPI cycles after the clock edge that took the change. Candidates do not move during the scan, except through R7.
- R9: A change that arrives during a scan restarts it from the first ID. The done pulse then comes NUM_SPI cycles after the later change.
- R10: A command whose cmd_id lies outside PRIV_IDS to PRIV_IDS+NUM_SPI-1 is ignored. It starts no scan and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_id | input | ID_W | Absolute interrupt ID of the command |
| cmd_prio | input | 8 | Priority for configure |
| cmd_grp | input | 1 | Group for configure |
| cmd_irm | input | 1 | Routing mode for configure: 1 is one-of-N |
| cmd_aff | input | 32 | Affinity word for configure: Aff3..Aff0 from bits 31:24 down to 7:0 |
| core_aff | input | NUM_CORE*8 | Affinity byte of each core |
| core_part | input | NUM_CORE*2 | One-of-N participation, bit 2c+g |
| grp_en | input | 2 | Group enables |
| cand_id | output | NUM_CORE*ID_W | Candidate ID per core |
| cand_prio | output | NUM_CORE*8 | Candidate priority per core, 0xFF means empty |
| cand_grp | output | NUM_CORE | Candidate group per core |
| done_o | output | 1 | One-cycle pulse when a scan has been published |

## Verification
The hardest situation to reach is the interplay between a clear and a scan. The bench has to show the emptied slot in the single cycle after a clear-pending command, before the new scan republishes. Another interrupt that was queued behind on the same core must then surface. The bench first stacks two interrupts on one core, then clears the winner and samples the candidate both on the next cycle and after the done pulse. The restart case is driven by issuing a second command twenty cycles into a scan. The bench then checks that no done pulse appears before NUM_SPI cycles have passed from the second command.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [2:0] {
        OP_SET_PEND = 3'd0,
        OP_CLR_PEND = 3'd1,
        OP_SET_EN   = 3'd2,
        OP_CLR_EN   = 3'd3,
        OP_SET_ACT  = 3'd4,
        OP_CLR_ACT  = 3'd5,
        OP_CONFIG   = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } st_e;

    localparam logic [7:0] PRIO_EMPTY = 8'hFF;
endpackage

// File: rtl/irq_arb_route.sv
module irq_arb_route #(
    parameter int NUM_CORE = 4,
    parameter int CORE_W   = 2
) (
    input  logic                  irm,
    input  logic [31:0]           aff,
    input  logic                  grp,
    input  logic [NUM_CORE*8-1:0] core_aff,
    input  logic [NUM_CORE*2-1:0] core_part,
    output logic                  hit,
    output logic [CORE_W-1:0]     core
);
    always_comb begin
        hit  = 1'b0;
        core = '0;
        for (int c = NUM_CORE - 1; c >= 0; c--) begin
            if (irm ? core_part[c*2 + int'(grp)]
                    : (aff[31:8] == 24'd0 && aff[7:0] == core_aff[c*8 +: 8])) begin
                hit  = 1'b1;
                core = CORE_W'(c);
            end
        end
    end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
    parameter int ID_W = 7
) (
    input  logic            elig,
    input  logic [7:0]      prio,
    input  logic [ID_W-1:0] id,
    input  logic [7:0]      cur_prio,
    input  logic [ID_W-1:0] cur_id,
    output logic            take
);
    assign take = elig && ((prio < cur_prio) || (prio == cur_prio && id < cur_id));
endmodule

// File: rtl/shared_irq_arbiter.sv
module shared_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int PRIV_IDS = 32,
    parameter int NUM_SPI  = 64,
    parameter int NUM_CORE = 4,
    localparam int ID_W    = $clog2(PRIV_IDS + NUM_SPI + 1),
    localparam int IDX_W   = $clog2(NUM_SPI),
    localparam int CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [ID_W-1:0]          cmd_id,
    input  logic [7:0]               cmd_prio,
    input  logic                     cmd_grp,
    input  logic                     cmd_irm,
    input  logic [31:0]              cmd_aff,
    input  logic [NUM_CORE*8-1:0]    core_aff,
    input  logic [NUM_CORE*2-1:0]    core_part,
    input  logic [1:0]               grp_en,
    output logic [NUM_CORE*ID_W-1:0] cand_id,
    output logic [NUM_CORE*8-1:0]    cand_prio,
    output logic [NUM_CORE-1:0]      cand_grp,
    output logic                     done_o
);
    // interrupt state bank
    logic [NUM_SPI-1:0]       pend_q, en_q, act_q, grp_q, irm_q;
    logic [NUM_SPI-1:0][7:0]  prio_q;
    logic [NUM_SPI-1:0][31:0] aff_q;

    // last seen core-side inputs, for change detection
    logic [NUM_CORE*2-1:0] part_q;
    logic [NUM_CORE*8-1:0] caff_q;
    logic [1:0]            gen_q;

    st_e              state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    logic [NUM_CORE-1:0][7:0]      work_prio, work_prio_n, cand_prio_q;
    logic [NUM_CORE-1:0][ID_W-1:0] work_id, work_id_n, cand_id_q;
    logic [NUM_CORE-1:0]           work_grp, work_grp_n, cand_grp_q;

    op_e              op;
    logic [ID_W-1:0]  cmd_off;
    logic [IDX_W-1:0] cidx;
    logic             cmd_hit, chg, last;
    logic [ID_W-1:0]  s_id;
    logic             elig_s, s_hit, c_hit;
    logic [CORE_W-1:0] s_core, c_core;

    assign op      = op_e'(cmd_op);
    assign cmd_off = cmd_id - ID_W'(PRIV_IDS);
    assign cidx    = cmd_off[IDX_W-1:0];
    assign cmd_hit = cmd_valid && (cmd_id >= ID_W'(PRIV_IDS))
                     && (cmd_id < ID_W'(PRIV_IDS + NUM_SPI));
    assign chg     = cmd_hit || (core_part != part_q) || (core_aff != caff_q)
                     || (grp_en != gen_q);
    assign last    = (idx_q == IDX_W'(NUM_SPI - 1));
    assign s_id    = ID_W'(PRIV_IDS) + ID_W'(idx_q);
    assign elig_s  = pend_q[idx_q] && en_q[idx_q] && !act_q[idx_q]
                     && grp_en[grp_q[idx_q]];

    irq_arb_route #(.NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) u_rt_scan (
        .irm(irm_q[idx_q]), .aff(aff_q[idx_q]), .grp(grp_q[idx_q]),
        .core_aff(core_aff), .core_part(core_part), .hit(s_hit), .core(s_core)
    );

    irq_arb_route #(.NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) u_rt_clr (
        .irm(irm_q[cidx]), .aff(aff_q[cidx]), .grp(grp_q[cidx]),
        .core_aff(core_aff), .core_part(core_part), .hit(c_hit), .core(c_core)
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        logic take;
        irq_arb_pick #(.ID_W(ID_W)) u_pick (
            .elig(elig_s && s_hit && (s_core == CORE_W'(c))),
            .prio(prio_q[idx_q]), .id(s_id),
            .cur_prio(work_prio[c]), .cur_id(work_id[c]), .take(take)
        );
        assign work_prio_n[c] = take ? prio_q[idx_q] : work_prio[c];
        assign work_id_n[c]   = take ? s_id : work_id[c];
        assign work_grp_n[c]  = take ? grp_q[idx_q] : work_grp[c];
        assign cand_prio[c*8 +: 8]     = cand_prio_q[c];
        assign cand_id[c*ID_W +: ID_W] = cand_id_q[c];
        assign cand_grp[c]             = cand_grp_q[c];
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (chg) state_d = ST_SCAN;
            ST_SCAN: if (!chg && last) state_d = ST_DONE;
            ST_DONE: state_d = chg ? ST_SCAN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done_o = (state_q == ST_DONE);
    end

    // bank, scan pointer and candidate registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0; en_q <= '0; act_q <= '0; grp_q <= '0; irm_q <= '0;
            prio_q <= '0; aff_q <= '0;
            part_q <= '0; caff_q <= '0; gen_q <= '0;
            idx_q  <= '0;
            for (int c = 0; c < NUM_CORE; c++) begin
                work_prio[c] <= PRIO_EMPTY; work_id[c] <= '1; work_grp[c] <= 1'b0;
                cand_prio_q[c] <= PRIO_EMPTY; cand_id_q[c] <= '1; cand_grp_q[c] <= 1'b0;
            end
        end else begin
            part_q <= core_part;
            caff_q <= core_aff;
            gen_q  <= grp_en;
            if (cmd_hit) begin
                case (op)
                    OP_SET_PEND: pend_q[cidx] <= 1'b1;
                    OP_CLR_PEND: pend_q[cidx] <= 1'b0;
                    OP_SET_EN:   en_q[cidx]   <= 1'b1;
                    OP_CLR_EN:   en_q[cidx]   <= 1'b0;
                    OP_SET_ACT:  act_q[cidx]  <= 1'b1;
                    OP_CLR_ACT:  act_q[cidx]  <= 1'b0;
                    OP_CONFIG: begin
                        prio_q[cidx] <= cmd_prio;
                        grp_q[cidx]  <= cmd_grp;
                        irm_q[cidx]  <= cmd_irm;
                        aff_q[cidx]  <= cmd_aff;
                    end
                    default: ;
                endcase
            end
            if (chg) begin
                idx_q <= '0;
                for (int c = 0; c < NUM_CORE; c++) begin
                    work_prio[c] <= PRIO_EMPTY; work_id[c] <= '1; work_grp[c] <= 1'b0;
                end
            end else if (state_q == ST_SCAN) begin
                idx_q     <= idx_q + 1'b1;
                work_prio <= work_prio_n;
                work_id   <= work_id_n;
                work_grp  <= work_grp_n;
                if (last) begin
                    cand_prio_q <= work_prio_n;
                    cand_id_q   <= work_id_n;
                    cand_grp_q  <= work_grp_n;
                end
            end
            if (cmd_hit && op == OP_CLR_PEND && c_hit)
                cand_prio_q[c_core] <= PRIO_EMPTY;
        end
    end
endmodule

// File: rtl/shared_irq_arbiter_chk.sv
module shared_irq_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int PRIV_IDS = 32,
    parameter int NUM_SPI  = 64,
    parameter int NUM_CORE = 4,
    parameter int ID_W     = 7,
    parameter int IDX_W    = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [2:0]               cmd_op,
    input logic [NUM_CORE*ID_W-1:0] cand_id,
    input logic [NUM_CORE*8-1:0]    cand_prio,
    input logic [NUM_CORE-1:0]      cand_grp,
    input logic                     done_o,
    input logic [1:0]               state_q,
    input logic [IDX_W-1:0]         idx_q,
    input logic                     chg
);
    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: candidates only move on publication or on a clear
    p_cand_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(cmd_valid && cmd_op == 3'(OP_CLR_PEND)))
        |-> ($stable(cand_id) && $stable(cand_grp) && $stable(cand_prio)));

    // R8: the scan advances one ID per clock while undisturbed
    p_scan_step_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == 2'(ST_SCAN) && !chg && idx_q != IDX_W'(NUM_SPI - 1))
        |=> (idx_q == $past(idx_q) + 1'b1));

    // R9: any change restarts the scan from the first ID
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        chg |=> (state_q == 2'(ST_SCAN) && idx_q == '0));

    // R2: a non-empty candidate always names a shared ID
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_rng
        p_id_range_r2: assert property (@(posedge clk) disable iff (rst)
            (cand_prio[c*8 +: 8] != PRIO_EMPTY)
            |-> (cand_id[c*ID_W +: ID_W] >= ID_W'(PRIV_IDS)
                 && cand_id[c*ID_W +: ID_W] < ID_W'(PRIV_IDS + NUM_SPI)));
    end
endmodule

bind shared_irq_arbiter shared_irq_arbiter_chk #(
    .PRIV_IDS(PRIV_IDS), .NUM_SPI(NUM_SPI), .NUM_CORE(NUM_CORE),
    .ID_W(ID_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cand_id(cand_id), .cand_prio(cand_prio), .cand_grp(cand_grp),
    .done_o(done_o), .state_q(state_q), .idx_q(idx_q), .chg(chg)
);

// File: tb/sim_shared_irq_arbiter.sv
`timescale 1ns/1ps
module sim_shared_irq_arbiter;
    localparam int PRIV = 32, NSPI = 64, NCORE = 4;
    localparam int ID_W = $clog2(PRIV + NSPI + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [ID_W-1:0] cmd_id = '0;
    logic [7:0] cmd_prio = '0;
    logic cmd_grp = 1'b0, cmd_irm = 1'b0;
    logic [31:0] cmd_aff = '0;
    logic [NCORE*8-1:0] core_aff = 32'h1312_1110;
    logic [NCORE*2-1:0] core_part = '0;
    logic [1:0] grp_en = 2'b11;
    logic [NCORE*ID_W-1:0] cand_id;
    logic [NCORE*8-1:0] cand_prio;
    logic [NCORE-1:0] cand_grp;
    logic done_o;
    int nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    shared_irq_arbiter #(.PRIV_IDS(PRIV), .NUM_SPI(NSPI), .NUM_CORE(NCORE)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .cmd_prio(cmd_prio), .cmd_grp(cmd_grp), .cmd_irm(cmd_irm), .cmd_aff(cmd_aff),
        .core_aff(core_aff), .core_part(core_part), .grp_en(grp_en),
        .cand_id(cand_id), .cand_prio(cand_prio), .cand_grp(cand_grp), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] prio_of(input int c);
        return 32'(cand_prio[c*8 +: 8]);
    endfunction
    function automatic logic [31:0] id_of(input int c);
        return 32'(cand_id[c*ID_W +: ID_W]);
    endfunction

    // drive one command for one cycle; returns at the negedge after the taking edge
    task automatic issue(input logic [2:0] op, input int id, input logic [7:0] p = 8'h00,
                         input logic g = 1'b0, input logic irm = 1'b0, input logic [31:0] a = 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = ID_W'(id);
        cmd_prio = p; cmd_grp = g; cmd_irm = irm; cmd_aff = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, output int cyc);
        cyc = 0;
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            nchk++; nerr++;
            $display("FAIL %s no done pulse actual=%0d expected=%0d", req, cyc, NSPI);
        end
    endtask

    task automatic run(input string req, input logic [2:0] op, input int id,
                       input logic [7:0] p = 8'h00, input logic g = 1'b0,
                       input logic irm = 1'b0, input logic [31:0] a = 0);
        int cyc;
        issue(op, id, p, g, irm, a);
        wait_done(req, cyc);
    endtask

    task automatic add_irq(input string req, input int id, input logic [7:0] p,
                           input logic g, input logic irm, input logic [31:0] a);
        run(req, 3'd6, id, p, g, irm, a);
        run(req, 3'd2, id);
        run(req, 3'd0, id);
    endtask

    task automatic set_inputs(input string req, input logic [NCORE*2-1:0] part, input logic [1:0] ge);
        int cyc;
        @(negedge clk);
        core_part = part; grp_en = ge;
        @(negedge clk);
        wait_done(req, cyc);
    endtask

    task automatic t_reset;
        for (int c = 0; c < NCORE; c++) chk("R1 reset empty", prio_of(c), 32'hFF);
        chk("R1 done low", 32'(done_o), 0);
    endtask

    task automatic t_eligible;
        run("R2", 3'd6, 40, 8'h20, 1'b0, 1'b0, 32'h11);
        run("R2", 3'd0, 40);
        chk("R2 pending but disabled", prio_of(1), 32'hFF);
        run("R2", 3'd2, 40);
        chk("R2 eligible prio", prio_of(1), 32'h20);
        chk("R2 eligible id", id_of(1), 40);
        run("R2", 3'd4, 40);
        chk("R2 active hidden", prio_of(1), 32'hFF);
        run("R2", 3'd5, 40);
        chk("R2 active cleared", prio_of(1), 32'h20);
        set_inputs("R2", core_part, 2'b10);
        chk("R2 group disabled", prio_of(1), 32'hFF);
        set_inputs("R2", core_part, 2'b11);
        chk("R2 group re-enabled", id_of(1), 40);
    endtask

    task automatic t_priority;
        add_irq("R3", 50, 8'h10, 1'b0, 1'b0, 32'h11);
        chk("R3 lower prio wins", id_of(1), 50);
        add_irq("R3", 45, 8'h10, 1'b1, 1'b0, 32'h11);
        chk("R3 tie lower id", id_of(1), 45);
        chk("R3 group reported", 32'(cand_grp[1]), 1);
        add_irq("R3", 60, 8'h10, 1'b0, 1'b0, 32'h11);
        chk("R3 higher id tie loses", id_of(1), 45);
    endtask

    task automatic t_direct;
        add_irq("R4", 70, 8'h30, 1'b0, 1'b0, 32'h13);
        chk("R4 direct id", id_of(3), 70);
        chk("R4 direct prio", prio_of(3), 32'h30);
        chk("R4 other core empty", prio_of(2), 32'hFF);
        chk("R4 core0 empty", prio_of(0), 32'hFF);
    endtask

    task automatic t_oneofn;
        add_irq("R5", 80, 8'h08, 1'b1, 1'b1, 32'h0);
        chk("R5 no participant", id_of(3), 70);
        set_inputs("R5", 8'b1010_0001, 2'b11);
        chk("R5 lowest willing core", id_of(2), 80);
        chk("R5 wrong group ignored", prio_of(0), 32'hFF);
        set_inputs("R5", 8'b1000_0001, 2'b11);
        chk("R5 next willing core", id_of(3), 80);
        chk("R5 prev core emptied", prio_of(2), 32'hFF);
    endtask

    task automatic t_noroute;
        add_irq("R6", 90, 8'h01, 1'b0, 1'b0, 32'h55);
        chk("R6 unmatched core0", prio_of(0), 32'hFF);
        chk("R6 others kept", id_of(1), 45);
        add_irq("R6", 91, 8'h01, 1'b0, 1'b0, 32'h0100_0010);
        chk("R6 upper affinity blocks", prio_of(0), 32'hFF);
        run("R6", 3'd6, 90, 8'h01, 1'b0, 1'b0, 32'h10);
        chk("R6 stayed pending", id_of(0), 90);
        chk("R6 stayed pending prio", prio_of(0), 32'h01);
    endtask

    task automatic t_clear;
        int cyc;
        issue(3'd1, 90);
        chk("R7 cleared slot immediate", prio_of(0), 32'hFF);
        chk("R7 other core untouched", prio_of(1), 32'h10);
        wait_done("R7", cyc);
        chk("R7 after scan", prio_of(0), 32'hFF);
        issue(3'd1, 45);
        chk("R7 winner slot immediate", prio_of(1), 32'hFF);
        wait_done("R7", cyc);
        chk("R7 next surfaces id", id_of(1), 50);
        chk("R7 next surfaces prio", prio_of(1), 32'h10);
    endtask

    task automatic t_timing;
        int cyc = 0;
        logic seen_mid = 1'b1;
        issue(3'd0, 60);
        while (!done_o && cyc < 300) begin
            if (cyc == 10 && (id_of(1) != 50 || prio_of(1) != 32'h10)) seen_mid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk("R8 scan latency", cyc, NSPI);
        chk("R8 stable mid-scan", 32'(seen_mid), 1);
        @(negedge clk);
        chk("R8 done one cycle", 32'(done_o), 0);
    endtask

    task automatic t_restart;
        int cyc = 0;
        int early = 0;
        issue(3'd0, 60);
        repeat (20) begin
            if (done_o) early++;
            @(negedge clk);
        end
        issue(3'd0, 61);
        while (!done_o && cyc < 300) begin
            @(negedge clk);
            cyc++;
        end
        chk("R9 no early done", early, 0);
        chk("R9 latency from later change", cyc, NSPI);
    endtask

    task automatic t_range;
        int seen = 0;
        issue(3'd6, 31, 8'h00, 1'b0, 1'b0, 32'h10);
        issue(3'd0, 31);
        issue(3'd2, 31);
        issue(3'd0, PRIV + NSPI);
        issue(3'd0, (1 << ID_W) - 1);
        repeat (NSPI + 5) begin
            if (done_o) seen++;
            @(negedge clk);
        end
        chk("R10 no scan started", seen, 0);
        chk("R10 core0 unchanged", prio_of(0), 32'hFF);
        chk("R10 core1 unchanged", id_of(1), 50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_eligible();
        t_priority();
        t_direct();
        t_oneofn();
        t_noroute();
        t_clear();
        t_timing();
        t_restart();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule